// File: doc/BRIEF.md
# Load/Store Ordering Queues with Speculative Load Issue

This block keeps memory accesses correct while loads leave the core out of program order. It holds a load queue and a separate store queue. Memory operations enter them one per cycle in program order, and each entry receives a sequence age from a shared counter. All ordering decisions compare these ages. When a load asks to issue, the block searches the older stores. The load then reads memory, takes its value from a store still in flight, or stays back. A load may issue even when an older store has not yet produced its address.

Mistakes from that speculation are found later. When a store's address arrives, every younger load that has already issued to an overlapping address is flagged for replay. When an older load issues to an address that a younger, already issued load also touched, the younger load is flagged in the same way. Replay requests appear as a registered mask of load slots. Flagged slots lose their issued status so they can issue again. A store may leave for execution only once no older load is still waiting. Loads free their slots at retirement and stores free theirs at commit, both from the head of their queue.

Top module: `lsq_disambig`

## Requirements
- R1: After reset both queues are empty: `lqFull` and `sqFull` are 0, `replayValid` is 0, `replayMask` is 0, both allocation indices are 0, and `ldAction` is 0 while no load request is present.
- R2: An accepted allocation takes the slot shown on `allocLdIdx` or `allocStIdx`, and that index advances by one modulo the queue depth. A full flag is high when the queue holds depth entries. An allocation of a kind whose queue is full is ignored: the index does not move and the full flag stays high.
- R3: A load request whose older stores include none with a known address overlapping the load returns `ldAction` = 1 (read memory). Access sizes are 0 = byte, 1 = halfword, 2 = word, with naturally aligned addresses. Two accesses overlap when their addresses agree after dropping the low bits of the larger size.
- R4: An older store whose address is still unknown does not hold back a load. The load returns `ldAction` = 1 and counts as issued.
- R5: The block returns `ldAction` = 2 (forward) under three conditions: the youngest older overlapping store has its data, its size is at least the load's size, and it covers the load's bytes. `ldFwdData` then holds the store data shifted right by 8 times the byte offset of the load inside the store, zero-extended from the load's width.
- R6: When several older stores overlap the load, only the one with the youngest age is used.
- R7: When the selected store is narrower than the load, or has no data yet, the result is `ldAction` = 3 (wait). The load is not marked issued.
- R8: Stores younger than the load never take part in its search.
- R9: In the cycle after a store receives its address, `replayMask` holds the slots of the younger loads that have already issued, or are issuing in that same cycle, to an overlapping address. `replayValid` is high only if that mask is non-zero.
- R10: In the cycle after a load issues (result 1 or 2), `replayMask` holds the slots of the younger loads that had already issued to an overlapping address.
- R11: `stIssueOk` is high only for a store that is present and has both its address and its data, and only when no older load is still unissued.
- R12: `ldRetire` frees the oldest load and `stCommit` frees the oldest store. A committed store is no longer seen by later loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Allocate one memory operation this cycle |
| allocIsStore | input | 1 | 1 = store, 0 = load |
| allocSize | input | 2 | Access size code of the new operation |
| allocLdIdx | output | LQ_IDX_W | Load slot taken by the next load allocation |
| allocStIdx | output | SQ_IDX_W | Store slot taken by the next store allocation |
| lqFull | output | 1 | Load queue holds LQ_DEPTH entries |
| sqFull | output | 1 | Store queue holds SQ_DEPTH entries |
| staValid | input | 1 | Store address arrives |
| staIdx | input | SQ_IDX_W | Store slot receiving the address |
| staAddr | input | ADDR_W | Store byte address |
| stdValid | input | 1 | Store data arrives |
| stdIdx | input | SQ_IDX_W | Store slot receiving the data |
| stdData | input | DATA_W | Store data, right-aligned |
| ldReqValid | input | 1 | Load asks to issue |
| ldReqIdx | input | LQ_IDX_W | Load slot asking |
| ldReqAddr | input | ADDR_W | Load byte address |
| ldAction | output | 2 | 0 none, 1 memory, 2 forward, 3 wait |
| ldFwdData | output | DATA_W | Forwarded load value |
| stIssueValid | input | 1 | Store asks to issue |
| stIssueIdx | input | SQ_IDX_W | Store slot asking |
| stIssueOk | output | 1 | Store may issue now |
| ldRetire | input | 1 | Free the oldest load |
| stCommit | input | 1 | Free the oldest store |
| replayValid | output | 1 | At least one load must replay |
| replayMask | output | LQ_DEPTH | Load slots to replay |

## Verification
The bench sweeps every pairing of store size, load size and aligned offset, with store data present and absent. This covers partial overlaps where a narrow store sits under a wide load, which a design with a loose covering test would wrongly forward, and neighbouring words that a coarse compare would wrongly treat as a match. Directed sequences then check the rest. One stack of three same-address stores sits around a load, so picking the oldest store or counting a younger one shows up as wrong data. A store that resolves under a load that has already speculated must replay exactly that load and not a load at another address. An older load issuing after a younger one must trap only the overlapping younger load. A store must be held back by an older unissued load. A committed store must stop forwarding.

// File: rtl/lsq_pkg.sv
`timescale 1ns/1ps
package lsq_pkg;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_MEM  = 2'd1,
    ACT_FWD  = 2'd2,
    ACT_WAIT = 2'd3
  } ld_act_e;

  // Strobes from the sequencing control to the entry datapath
  typedef struct packed {
    logic allocLd;
    logic allocSt;
    logic freeLd;
    logic freeSt;
  } lsq_strobe_t;

endpackage

// File: rtl/lsq_ctrl.sv
`timescale 1ns/1ps
module lsq_ctrl
  import lsq_pkg::*;
#(
  parameter int LQ_DEPTH = 4,
  parameter int SQ_DEPTH = 4,
  parameter int LQ_IDX_W = $clog2(LQ_DEPTH),
  parameter int SQ_IDX_W = $clog2(SQ_DEPTH),
  parameter int AGE_W    = $clog2(LQ_DEPTH + SQ_DEPTH) + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                allocValid,
  input  logic                allocIsStore,
  input  logic                ldRetire,
  input  logic                stCommit,
  output lsq_strobe_t         stb,
  output logic [LQ_IDX_W-1:0] ldHead,
  output logic [LQ_IDX_W-1:0] ldTail,
  output logic [SQ_IDX_W-1:0] stHead,
  output logic [SQ_IDX_W-1:0] stTail,
  output logic [AGE_W-1:0]    allocAge,
  output logic                lqFull,
  output logic                sqFull
);

  localparam int LQ_CNT_W = $clog2(LQ_DEPTH + 1);
  localparam int SQ_CNT_W = $clog2(SQ_DEPTH + 1);

  logic [LQ_CNT_W-1:0] ldCount;
  logic [SQ_CNT_W-1:0] stCount;

  function automatic logic [LQ_IDX_W-1:0] ldNext(input logic [LQ_IDX_W-1:0] p);
    return (p == LQ_IDX_W'(LQ_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [SQ_IDX_W-1:0] stNext(input logic [SQ_IDX_W-1:0] p);
    return (p == SQ_IDX_W'(SQ_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign lqFull = (ldCount == LQ_CNT_W'(LQ_DEPTH));
  assign sqFull = (stCount == SQ_CNT_W'(SQ_DEPTH));

  always_comb begin
    stb.allocLd = allocValid && !allocIsStore && !lqFull;
    stb.allocSt = allocValid &&  allocIsStore && !sqFull;
    stb.freeLd  = ldRetire && (ldCount != '0);
    stb.freeSt  = stCommit && (stCount != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ldHead   <= '0;
      ldTail   <= '0;
      stHead   <= '0;
      stTail   <= '0;
      ldCount  <= '0;
      stCount  <= '0;
      allocAge <= '0;
    end else begin
      if (stb.allocLd) ldTail <= ldNext(ldTail);
      if (stb.freeLd)  ldHead <= ldNext(ldHead);
      if (stb.allocSt) stTail <= stNext(stTail);
      if (stb.freeSt)  stHead <= stNext(stHead);
      if (stb.allocLd && !stb.freeLd)      ldCount <= ldCount + 1'b1;
      else if (!stb.allocLd && stb.freeLd) ldCount <= ldCount - 1'b1;
      if (stb.allocSt && !stb.freeSt)      stCount <= stCount + 1'b1;
      else if (!stb.allocSt && stb.freeSt) stCount <= stCount - 1'b1;
      if (stb.allocLd || stb.allocSt) allocAge <= allocAge + 1'b1;
    end
  end

  // R2
  lq_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    ldCount <= LQ_CNT_W'(LQ_DEPTH));

  // R2
  sq_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    stCount <= SQ_CNT_W'(SQ_DEPTH));

  // R2
  lq_full_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lqFull && allocValid && !allocIsStore) |=> (ldTail == $past(ldTail)));

endmodule

// File: rtl/lsq_datapath.sv
`timescale 1ns/1ps
module lsq_datapath
  import lsq_pkg::*;
#(
  parameter int LQ_DEPTH = 4,
  parameter int SQ_DEPTH = 4,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int LQ_IDX_W = $clog2(LQ_DEPTH),
  parameter int SQ_IDX_W = $clog2(SQ_DEPTH),
  parameter int AGE_W    = $clog2(LQ_DEPTH + SQ_DEPTH) + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  lsq_strobe_t         stb,
  input  logic [LQ_IDX_W-1:0] allocLdIdx,
  input  logic [SQ_IDX_W-1:0] allocStIdx,
  input  logic [AGE_W-1:0]    allocAge,
  input  logic [1:0]          allocSize,
  input  logic [LQ_IDX_W-1:0] freeLdIdx,
  input  logic [SQ_IDX_W-1:0] freeStIdx,
  input  logic                staValid,
  input  logic [SQ_IDX_W-1:0] staIdx,
  input  logic [ADDR_W-1:0]   staAddr,
  input  logic                stdValid,
  input  logic [SQ_IDX_W-1:0] stdIdx,
  input  logic [DATA_W-1:0]   stdData,
  input  logic                ldReqValid,
  input  logic [LQ_IDX_W-1:0] ldReqIdx,
  input  logic [ADDR_W-1:0]   ldReqAddr,
  output ld_act_e             ldAction,
  output logic [DATA_W-1:0]   ldFwdData,
  input  logic                stIssueValid,
  input  logic [SQ_IDX_W-1:0] stIssueIdx,
  output logic                stIssueOk,
  output logic                replayValid,
  output logic [LQ_DEPTH-1:0] replayMask
);

  localparam int OFF_W = $clog2(DATA_W / 8);

  // Load queue state
  logic [LQ_DEPTH-1:0] ldValid, ldIssued, ldAddrValid;
  logic [AGE_W-1:0]    ldAge  [LQ_DEPTH];
  logic [1:0]          ldSize [LQ_DEPTH];
  logic [ADDR_W-1:0]   ldAddr [LQ_DEPTH];

  // Store queue state
  logic [SQ_DEPTH-1:0] stValid, stIssued, stAddrValid, stDataValid;
  logic [AGE_W-1:0]    stAge  [SQ_DEPTH];
  logic [1:0]          stSize [SQ_DEPTH];
  logic [ADDR_W-1:0]   stAddr [SQ_DEPTH];
  logic [DATA_W-1:0]   stData [SQ_DEPTH];

  // a strictly older than b, modulo the age range
  function automatic logic isOlder(input logic [AGE_W-1:0] a, input logic [AGE_W-1:0] b);
    logic [AGE_W-1:0] d;
    d = b - a;
    return (d != '0) && !d[AGE_W-1];
  endfunction

  function automatic logic spanHit(input logic [ADDR_W-1:0] a, input logic [1:0] sa,
                                   input logic [ADDR_W-1:0] b, input logic [1:0] sb);
    logic [1:0] m;
    m = (sa > sb) ? sa : sb;
    return (a >> m) == (b >> m);
  endfunction

  function automatic logic covers(input logic [ADDR_W-1:0] sAddr, input logic [1:0] sSz,
                                  input logic [ADDR_W-1:0] lAddr, input logic [1:0] lSz);
    return (sSz >= lSz) && ((sAddr >> sSz) == (lAddr >> sSz));
  endfunction

  function automatic logic [DATA_W-1:0] widthMask(input logic [1:0] sz);
    case (sz)
      2'd0:    return DATA_W'(8'hFF);
      2'd1:    return DATA_W'(16'hFFFF);
      default: return '1;
    endcase
  endfunction

  // ---------------- load search over older stores ----------------
  logic [AGE_W-1:0]    reqAge;
  logic [1:0]          reqSize;
  logic                reqLive;
  logic [SQ_DEPTH-1:0] cand, youngest;
  logic                hit;
  logic [ADDR_W-1:0]   selAddr;
  logic [1:0]          selSize;
  logic [DATA_W-1:0]   selData;
  logic                selHasData;
  logic [OFF_W-1:0]    selOff;
  logic                ldIssueNow;

  always_comb begin
    reqAge  = ldAge[ldReqIdx];
    reqSize = ldSize[ldReqIdx];
    reqLive = ldReqValid && ldValid[ldReqIdx];
    for (int j = 0; j < SQ_DEPTH; j++) begin
      cand[j] = stValid[j] && stAddrValid[j] && isOlder(stAge[j], reqAge) &&
                spanHit(stAddr[j], stSize[j], ldReqAddr, reqSize);
    end
    for (int j = 0; j < SQ_DEPTH; j++) begin
      youngest[j] = cand[j];
      for (int k = 0; k < SQ_DEPTH; k++) begin
        if (k != j && cand[k] && isOlder(stAge[j], stAge[k])) youngest[j] = 1'b0;
      end
    end
    hit        = |cand;
    selAddr    = '0;
    selSize    = '0;
    selData    = '0;
    selHasData = 1'b0;
    for (int j = 0; j < SQ_DEPTH; j++) begin
      if (youngest[j]) begin
        selAddr    = stAddr[j];
        selSize    = stSize[j];
        selData    = stData[j];
        selHasData = stDataValid[j];
      end
    end
    selOff = ldReqAddr[OFF_W-1:0] - selAddr[OFF_W-1:0];
    if (!reqLive)                                                        ldAction = ACT_NONE;
    else if (!hit)                                                       ldAction = ACT_MEM;
    else if (selHasData && covers(selAddr, selSize, ldReqAddr, reqSize)) ldAction = ACT_FWD;
    else                                                                 ldAction = ACT_WAIT;
    ldFwdData  = (selData >> {selOff, 3'b000}) & widthMask(reqSize);
    ldIssueNow = (ldAction == ACT_MEM) || (ldAction == ACT_FWD);
  end

  // ---------------- ordering violation search ----------------
  logic [AGE_W-1:0]    sAge;
  logic [1:0]          sSize;
  logic                staLive;
  logic [LQ_DEPTH-1:0] llHit, stHit, replayNext;

  assign sAge    = stAge[staIdx];
  assign sSize   = stSize[staIdx];
  assign staLive = staValid && stValid[staIdx];

  for (genvar i = 0; i < LQ_DEPTH; i++) begin : g_ldChk
    assign llHit[i] = ldIssueNow && ldValid[i] && ldIssued[i] && ldAddrValid[i] &&
                      isOlder(reqAge, ldAge[i]) &&
                      spanHit(ldAddr[i], ldSize[i], ldReqAddr, reqSize);
    assign stHit[i] = staLive && ldValid[i] && isOlder(sAge, ldAge[i]) &&
                      ((ldIssued[i] && ldAddrValid[i] &&
                        spanHit(ldAddr[i], ldSize[i], staAddr, sSize)) ||
                       (ldIssueNow && (ldReqIdx == LQ_IDX_W'(i)) &&
                        spanHit(ldReqAddr, reqSize, staAddr, sSize)));
  end

  assign replayNext  = llHit | stHit;
  assign replayValid = |replayMask;

  // ---------------- store issue gate ----------------
  logic olderPending;

  always_comb begin
    olderPending = 1'b0;
    for (int i = 0; i < LQ_DEPTH; i++) begin
      if (ldValid[i] && !ldIssued[i] && isOlder(ldAge[i], stAge[stIssueIdx]))
        olderPending = 1'b1;
    end
    stIssueOk = stIssueValid && stValid[stIssueIdx] && stAddrValid[stIssueIdx] &&
                stDataValid[stIssueIdx] && !olderPending;
  end

  // ---------------- state update ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ldValid     <= '0;
      ldIssued    <= '0;
      ldAddrValid <= '0;
      stValid     <= '0;
      stIssued    <= '0;
      stAddrValid <= '0;
      stDataValid <= '0;
      replayMask  <= '0;
      for (int i = 0; i < LQ_DEPTH; i++) begin
        ldAge[i]  <= '0;
        ldSize[i] <= '0;
        ldAddr[i] <= '0;
      end
      for (int j = 0; j < SQ_DEPTH; j++) begin
        stAge[j]  <= '0;
        stSize[j] <= '0;
        stAddr[j] <= '0;
        stData[j] <= '0;
      end
    end else begin
      if (stb.allocLd) begin
        ldValid[allocLdIdx]     <= 1'b1;
        ldAge[allocLdIdx]       <= allocAge;
        ldSize[allocLdIdx]      <= allocSize;
        ldAddrValid[allocLdIdx] <= 1'b0;
        ldIssued[allocLdIdx]    <= 1'b0;
      end
      if (stb.freeLd) ldValid[freeLdIdx] <= 1'b0;
      if (reqLive) begin
        ldAddr[ldReqIdx]      <= ldReqAddr;
        ldAddrValid[ldReqIdx] <= 1'b1;
        if (ldIssueNow) ldIssued[ldReqIdx] <= 1'b1;
      end
      for (int i = 0; i < LQ_DEPTH; i++) begin
        if (replayNext[i]) ldIssued[i] <= 1'b0;
      end
      replayMask <= replayNext;

      if (stb.allocSt) begin
        stValid[allocStIdx]     <= 1'b1;
        stAge[allocStIdx]       <= allocAge;
        stSize[allocStIdx]      <= allocSize;
        stAddrValid[allocStIdx] <= 1'b0;
        stDataValid[allocStIdx] <= 1'b0;
        stIssued[allocStIdx]    <= 1'b0;
      end
      if (stb.freeSt) stValid[freeStIdx] <= 1'b0;
      if (staLive) begin
        stAddr[staIdx]      <= staAddr;
        stAddrValid[staIdx] <= 1'b1;
      end
      if (stdValid && stValid[stdIdx]) begin
        stData[stdIdx]      <= stdData;
        stDataValid[stdIdx] <= 1'b1;
      end
      if (stIssueOk) stIssued[stIssueIdx] <= 1'b1;
    end
  end

  // R9 R10
  replay_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    replayValid |-> ((replayMask & ldIssued) == '0));

  // R12
  ld_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.freeLd |=> !ldValid[$past(freeLdIdx)]);

  // R12
  st_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.freeSt |=> !stValid[$past(freeStIdx)]);

  // R11
  st_issue_mark_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stIssueOk && !(stb.freeSt && freeStIdx == stIssueIdx)) |=> stIssued[$past(stIssueIdx)]);

endmodule

// File: rtl/lsq_disambig.sv
`timescale 1ns/1ps
module lsq_disambig
  import lsq_pkg::*;
#(
  parameter int LQ_DEPTH = 4,
  parameter int SQ_DEPTH = 4,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  localparam int LQ_IDX_W = $clog2(LQ_DEPTH),
  localparam int SQ_IDX_W = $clog2(SQ_DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                allocValid,
  input  logic                allocIsStore,
  input  logic [1:0]          allocSize,
  output logic [LQ_IDX_W-1:0] allocLdIdx,
  output logic [SQ_IDX_W-1:0] allocStIdx,
  output logic                lqFull,
  output logic                sqFull,
  input  logic                staValid,
  input  logic [SQ_IDX_W-1:0] staIdx,
  input  logic [ADDR_W-1:0]   staAddr,
  input  logic                stdValid,
  input  logic [SQ_IDX_W-1:0] stdIdx,
  input  logic [DATA_W-1:0]   stdData,
  input  logic                ldReqValid,
  input  logic [LQ_IDX_W-1:0] ldReqIdx,
  input  logic [ADDR_W-1:0]   ldReqAddr,
  output logic [1:0]          ldAction,
  output logic [DATA_W-1:0]   ldFwdData,
  input  logic                stIssueValid,
  input  logic [SQ_IDX_W-1:0] stIssueIdx,
  output logic                stIssueOk,
  input  logic                ldRetire,
  input  logic                stCommit,
  output logic                replayValid,
  output logic [LQ_DEPTH-1:0] replayMask
);

  localparam int AGE_W = $clog2(LQ_DEPTH + SQ_DEPTH) + 1;

  lsq_strobe_t         stb;
  logic [LQ_IDX_W-1:0] ldHead;
  logic [SQ_IDX_W-1:0] stHead;
  logic [AGE_W-1:0]    allocAge;
  ld_act_e             actionE;

  lsq_ctrl #(
    .LQ_DEPTH(LQ_DEPTH), .SQ_DEPTH(SQ_DEPTH),
    .LQ_IDX_W(LQ_IDX_W), .SQ_IDX_W(SQ_IDX_W), .AGE_W(AGE_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN),
    .allocValid(allocValid), .allocIsStore(allocIsStore),
    .ldRetire(ldRetire), .stCommit(stCommit),
    .stb(stb),
    .ldHead(ldHead), .ldTail(allocLdIdx),
    .stHead(stHead), .stTail(allocStIdx),
    .allocAge(allocAge), .lqFull(lqFull), .sqFull(sqFull)
  );

  lsq_datapath #(
    .LQ_DEPTH(LQ_DEPTH), .SQ_DEPTH(SQ_DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .LQ_IDX_W(LQ_IDX_W), .SQ_IDX_W(SQ_IDX_W), .AGE_W(AGE_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .allocLdIdx(allocLdIdx), .allocStIdx(allocStIdx),
    .allocAge(allocAge), .allocSize(allocSize),
    .freeLdIdx(ldHead), .freeStIdx(stHead),
    .staValid(staValid), .staIdx(staIdx), .staAddr(staAddr),
    .stdValid(stdValid), .stdIdx(stdIdx), .stdData(stdData),
    .ldReqValid(ldReqValid), .ldReqIdx(ldReqIdx), .ldReqAddr(ldReqAddr),
    .ldAction(actionE), .ldFwdData(ldFwdData),
    .stIssueValid(stIssueValid), .stIssueIdx(stIssueIdx), .stIssueOk(stIssueOk),
    .replayValid(replayValid), .replayMask(replayMask)
  );

  assign ldAction = actionE;

endmodule

// File: tb/test_lsq_disambig.sv
`timescale 1ns/1ps
module test_lsq_disambig;

  logic        clk = 1'b0;
  logic        rstN;
  logic        allocValid, allocIsStore;
  logic [1:0]  allocSize;
  logic [1:0]  allocLdIdx, allocStIdx;
  logic        lqFull, sqFull;
  logic        staValid;
  logic [1:0]  staIdx;
  logic [7:0]  staAddr;
  logic        stdValid;
  logic [1:0]  stdIdx;
  logic [31:0] stdData;
  logic        ldReqValid;
  logic [1:0]  ldReqIdx;
  logic [7:0]  ldReqAddr;
  logic [1:0]  ldAction;
  logic [31:0] ldFwdData;
  logic        stIssueValid;
  logic [1:0]  stIssueIdx;
  logic        stIssueOk;
  logic        ldRetire, stCommit;
  logic        replayValid;
  logic [3:0]  replayMask;

  int total = 0;
  int bad   = 0;
  int mLdHead = 0, mLdTail = 0, mStHead = 0, mStTail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lsq_disambig i_lsq_disambig (
    .clk(clk), .rstN(rstN),
    .allocValid(allocValid), .allocIsStore(allocIsStore), .allocSize(allocSize),
    .allocLdIdx(allocLdIdx), .allocStIdx(allocStIdx), .lqFull(lqFull), .sqFull(sqFull),
    .staValid(staValid), .staIdx(staIdx), .staAddr(staAddr),
    .stdValid(stdValid), .stdIdx(stdIdx), .stdData(stdData),
    .ldReqValid(ldReqValid), .ldReqIdx(ldReqIdx), .ldReqAddr(ldReqAddr),
    .ldAction(ldAction), .ldFwdData(ldFwdData),
    .stIssueValid(stIssueValid), .stIssueIdx(stIssueIdx), .stIssueOk(stIssueOk),
    .ldRetire(ldRetire), .stCommit(stCommit),
    .replayValid(replayValid), .replayMask(replayMask)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr();
    allocValid = 0; allocIsStore = 0; allocSize = 0;
    staValid = 0; staIdx = 0; staAddr = 0;
    stdValid = 0; stdIdx = 0; stdData = 0;
    ldReqValid = 0; ldReqIdx = 0; ldReqAddr = 0;
    stIssueValid = 0; stIssueIdx = 0;
    ldRetire = 0; stCommit = 0;
  endtask

  task automatic allocLd(input int sz, output int idx);
    @(negedge clk); clr();
    chk("R2 load index", allocLdIdx, mLdTail);
    allocValid = 1; allocIsStore = 0; allocSize = 2'(sz);
    idx = mLdTail; mLdTail = (mLdTail + 1) % 4;
  endtask

  task automatic allocSt(input int sz, output int idx);
    @(negedge clk); clr();
    chk("R2 store index", allocStIdx, mStTail);
    allocValid = 1; allocIsStore = 1; allocSize = 2'(sz);
    idx = mStTail; mStTail = (mStTail + 1) % 4;
  endtask

  task automatic resolveSt(input int idx, input int addr, input bit giveData, input logic [31:0] d);
    @(negedge clk); clr();
    staValid = 1; staIdx = 2'(idx); staAddr = 8'(addr);
    stdValid = giveData; stdIdx = 2'(idx); stdData = d;
  endtask

  task automatic ldIssue(input int idx, input int addr, input int expAct,
                         input logic [31:0] expData, input string req);
    @(negedge clk); clr();
    ldReqValid = 1; ldReqIdx = 2'(idx); ldReqAddr = 8'(addr);
    #1;
    chk(req, ldAction, expAct);
    if (expAct == 2) chk({req, " data"}, ldFwdData, expData);
  endtask

  task automatic expectReplay(input int mask, input string req);
    @(negedge clk); clr();
    chk(req, replayMask, mask);
    chk({req, " valid"}, replayValid, mask != 0);
  endtask

  task automatic stIssue(input int idx, input bit exp, input string req);
    @(negedge clk); clr();
    stIssueValid = 1; stIssueIdx = 2'(idx);
    #1;
    chk(req, stIssueOk, exp);
  endtask

  task automatic freeOps(input bit ld, input bit st);
    @(negedge clk); clr();
    ldRetire = ld; stCommit = st;
    if (ld) mLdHead = (mLdHead + 1) % 4;
    if (st) mStHead = (mStHead + 1) % 4;
  endtask

  function automatic logic [31:0] maskOf(input int sz);
    return (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int a, b, c, d, s0, s1, s2;
    int it;
    clr();
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;

    // R1 reset state
    chk("R1 lqFull", lqFull, 0);
    chk("R1 sqFull", sqFull, 0);
    chk("R1 replayValid", replayValid, 0);
    chk("R1 replayMask", replayMask, 0);
    chk("R1 allocLdIdx", allocLdIdx, 0);
    chk("R1 allocStIdx", allocStIdx, 0);
    chk("R1 ldAction idle", ldAction, 0);

    // R2 fill load queue, extra allocation ignored
    for (int i = 0; i < 4; i++) allocLd(2, a);
    @(negedge clk); clr();
    chk("R2 lqFull", lqFull, 1);
    allocValid = 1; allocIsStore = 0;
    @(negedge clk); clr();
    chk("R2 full alloc ignored idx", allocLdIdx, mLdTail);
    chk("R2 full stays", lqFull, 1);
    for (int i = 0; i < 4; i++) freeOps(1, 0);
    @(negedge clk); clr();
    chk("R2 lq empty", lqFull, 0);
    for (int i = 0; i < 4; i++) allocSt(2, a);
    @(negedge clk); clr();
    chk("R2 sqFull", sqFull, 1);
    for (int i = 0; i < 4; i++) freeOps(0, 1);

    // R4 speculation, R9 store resolution replay, R5 forward after replay
    allocSt(2, s0);
    allocLd(2, a);
    allocLd(2, b);
    ldIssue(a, 'h20, 1, 0, "R4 speculate past unknown store");
    ldIssue(b, 'h24, 1, 0, "R3 other word to memory");
    resolveSt(s0, 'h20, 1, 32'hCAFE_F00D);
    expectReplay(1 << a, "R9 store resolve replay");
    ldIssue(a, 'h20, 2, 32'hCAFE_F00D, "R5 forward on reissue");
    freeOps(1, 1);
    freeOps(1, 0);

    // R10 load-load trap
    allocLd(2, a);
    allocLd(2, b);
    allocLd(2, c);
    allocLd(2, d);
    ldIssue(b, 'h30, 1, 0, "R10 younger issues first");
    ldIssue(a, 'h30, 1, 0, "R10 older issues");
    expectReplay(1 << b, "R10 load-load trap");
    ldIssue(d, 'h34, 1, 0, "R10 younger other addr");
    ldIssue(c, 'h38, 1, 0, "R10 older other addr");
    expectReplay(0, "R10 no trap without overlap");
    for (int i = 0; i < 4; i++) freeOps(1, 0);

    // R6 youngest older store, R8 younger store ignored
    allocSt(2, s0);
    allocSt(2, s1);
    allocLd(2, a);
    allocSt(2, s2);
    resolveSt(s0, 'h10, 1, 32'h1111_1111);
    resolveSt(s1, 'h10, 1, 32'h2222_2222);
    resolveSt(s2, 'h10, 1, 32'h3333_3333);
    ldIssue(a, 'h10, 2, 32'h2222_2222, "R6 R8 youngest older store");
    freeOps(1, 1);
    freeOps(0, 1);
    freeOps(0, 1);

    // R11 store issue gate
    allocLd(2, a);
    allocSt(2, s0);
    allocSt(2, s1);
    resolveSt(s0, 'h50, 1, 32'h5);
    resolveSt(s1, 'h54, 0, 0);
    stIssue(s0, 0, "R11 older load pending");
    ldIssue(a, 'h58, 1, 0, "R11 older load issues");
    stIssue(s0, 1, "R11 store may issue");
    stIssue(s1, 0, "R11 store without data");
    freeOps(1, 1);
    freeOps(0, 1);

    // R12 committed store is gone
    allocSt(2, s0);
    resolveSt(s0, 'h60, 1, 32'h6);
    freeOps(0, 1);
    allocLd(2, a);
    ldIssue(a, 'h60, 1, 0, "R12 committed store not seen");
    freeOps(1, 0);

    // Sweep of sizes, offsets and data presence: R3 R5 R7
    it = 0;
    for (int s = 0; s < 3; s++)
      for (int so = 0; so < 4; so += (1 << s))
        for (int l = 0; l < 3; l++)
          for (int lo = 0; lo < 8; lo += (1 << l))
            for (int dk = 0; dk < 2; dk++) begin
              int sa, la, m, expA;
              bit ov, cv;
              logic [31:0] dat, expD;
              it++;
              sa  = 'h40 + so;
              la  = 'h40 + lo;
              m   = (s > l) ? s : l;
              ov  = (sa >> m) == (la >> m);
              cv  = (s >= l) && ((sa >> s) == (la >> s));
              dat = {8'(it), 8'hA5 ^ 8'(it), 8'h3C, 8'(it * 7)};
              expA = !ov ? 1 : (cv && dk) ? 2 : 3;
              expD = (dat >> (8 * (la - sa))) & maskOf(l);
              allocSt(s, s0);
              allocLd(l, a);
              resolveSt(s0, sa, dk[0], dat);
              ldIssue(a, la, expA, expD,
                      (expA == 1) ? "R3 sweep memory" : (expA == 2) ? "R5 sweep forward" : "R7 sweep wait");
              freeOps(1, 1);
            end

    @(negedge clk); clr();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule